// File: doc/BRIEF.md
# Dual-Granularity SPI Bit-Clock Generator

This block produces the serial bit clock for an SPI controller operating as bus master. It divides a reference clock in one of two ways. In coarse mode a 4-bit divider code selects a power-of-two ratio. In fine mode an 8-bit extension code is placed above that same 4-bit code to form a 12-bit value, and the ratio is that value plus one. Besides the clock level, the block gives a shift engine two one-cycle strobes: one marks a rising edge of the bit clock and one marks a falling edge.

The generator runs only while both the master enable and the run enable are high. While it is stopped, it keeps resampling the divider configuration. Once it starts, it holds the sampled ratio until it is stopped again. Every bit-clock period begins with its low phase. When the ratio is odd, the high phase is the shorter of the two. None of the pins carries a data stream, so all of them are plain control and status levels with no valid/ready handshake.

Top module: `spi_clk_gen`

## Requirements
- R1: With `fine_mode` = 0, the bit-clock period is 2^`div_code` reference cycles: code 0 gives 1 and code 15 gives 32768. `ext_code` has no effect in this mode.
- R2: With `fine_mode` = 1, the period is {`ext_code`,`div_code`} + 1 reference cycles, where `ext_code` supplies the upper 8 bits of the 12-bit value. This covers every ratio from 1 to 4096.
- R3: For a ratio R of 2 or more, each period starts with a low phase of R - floor(R/2) cycles, followed by a high phase of floor(R/2) cycles. The first rising edge comes R - floor(R/2) cycles after the clock edge that starts the generator.
- R4: For a ratio of 1, `sclk` toggles on every reference cycle. One strobe fires on every cycle, alternating between rise and fall. The first rise comes one cycle after the start edge.
- R5: `rise_stb` is high exactly in the cycle in which `sclk` has just changed from 0 to 1. `fall_stb` is high exactly in the cycle in which `sclk` has just changed from 1 to 0. The two strobes are never high in the same cycle.
- R6: While `master_en` or `run_en` is low, `sclk` stays at 0 and neither strobe fires.
- R7: Changes to `div_code`, `ext_code` or `fine_mode` made while the generator is running do not affect the period. The new setting takes effect at the next start.
- R8: When `run_en` falls, `sclk` is 0 in the next cycle. If `sclk` was high, `fall_stb` fires in that cycle.
- R9: While reset is held, `sclk`, `rise_stb` and `fall_stb` are all 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| div_code | input | 4 | Base divider code |
| ext_code | input | 8 | Extension code; upper bits of the fine ratio |
| fine_mode | input | 1 | 1 selects the linear ratio, 0 selects the power-of-two ratio |
| master_en | input | 1 | Controller is configured as bus master |
| run_en | input | 1 | Request to generate the bit clock |
| sclk | output | 1 | Generated bit-clock level; idle level is 0 |
| rise_stb | output | 1 | One-cycle strobe marking a rising edge of `sclk` |
| fall_stb | output | 1 | One-cycle strobe marking a falling edge of `sclk` |

## Verification
Two events can land on the same cycle. The first pair is the end of a high phase and a stop request: dropping `run_en` on the very cycle a rise strobe appears means the forced return to idle and the falling-edge strobe must be issued together, and the bench checks that `sclk` reads 0 with `fall_stb` set on the next cycle. The second pair is a configuration change and the running count: a new divider code is applied mid-period, and the distance to the next rising strobe is measured, which must still equal the ratio sampled at start. Throughout every measured vector, the bench also counts any cycle in which both strobes are high.

// File: rtl/spi_clk_gen_pkg.sv
package spi_clk_gen_pkg;

  // Width that holds both the largest power-of-two ratio and the largest linear ratio.
  function automatic int ratio_width(input int div_w, input int ext_w);
    int pow_w;
    int lin_w;
    pow_w = (1 << div_w);
    lin_w = div_w + ext_w + 1;
    return (pow_w > lin_w) ? pow_w : lin_w;
  endfunction

  typedef enum logic [1:0] {
    DIV_IDLE  = 2'd0,
    DIV_RUN   = 2'd1,
    DIV_BYPASS = 2'd2
  } div_state_e;

endpackage

// File: rtl/spi_div_ratio.sv
module spi_div_ratio #(
  parameter int DIV_W   = 4,
  parameter int EXT_W   = 8,
  parameter int RATIO_W = 16
) (
  input  logic [DIV_W-1:0]   div_code,
  input  logic [EXT_W-1:0]   ext_code,
  input  logic               fine_mode,
  output logic [RATIO_W-1:0] ratio
);

  localparam int POW_N = 1 << DIV_W;
  localparam int LIN_W = DIV_W + EXT_W;

  logic [RATIO_W-1:0] coarse_ratio;
  logic [RATIO_W-1:0] fine_ratio;
  logic [LIN_W-1:0]   lin_val;

  // Power-of-two ratio as a one-hot decode of the divider code.
  genvar gi;
  generate
    for (gi = 0; gi < RATIO_W; gi++) begin : g_pow
      if (gi < POW_N) begin : g_bit
        assign coarse_ratio[gi] = (div_code == DIV_W'(gi));
      end else begin : g_zero
        assign coarse_ratio[gi] = 1'b0;
      end
    end
  endgenerate

  assign lin_val    = {ext_code, div_code};
  assign fine_ratio = RATIO_W'(lin_val) + RATIO_W'(1);
  assign ratio      = fine_mode ? fine_ratio : coarse_ratio;

  // R1
  ratio_onehot_chk: assert final (fine_mode || $onehot(coarse_ratio));

endmodule

// File: rtl/spi_div_phase.sv
module spi_div_phase
  import spi_clk_gen_pkg::*;
#(
  parameter int RATIO_W = 16
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               go,
  input  logic [RATIO_W-1:0] ratio_in,
  output logic               sclk,
  output logic               rise_stb,
  output logic               fall_stb
);

  div_state_e         state_q, state_d;
  logic [RATIO_W-1:0] ratio_q;
  logic [RATIO_W-1:0] cnt_q, cnt_d;
  logic [RATIO_W-1:0] hi_len, lo_len;
  logic               sclk_q, sclk_d;
  logic               rise_q, fall_q;

  assign hi_len = ratio_q >> 1;
  assign lo_len = ratio_q - hi_len;

  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    sclk_d  = sclk_q;
    if (!go) begin
      state_d = DIV_IDLE;
      cnt_d   = '0;
      sclk_d  = 1'b0;
    end else begin
      unique case (state_q)
        DIV_IDLE: begin
          state_d = (ratio_in <= RATIO_W'(1)) ? DIV_BYPASS : DIV_RUN;
          cnt_d   = '0;
          sclk_d  = 1'b0;
        end
        DIV_BYPASS: begin
          cnt_d  = '0;
          sclk_d = ~sclk_q;
        end
        default: begin
          cnt_d  = (cnt_q == ratio_q - RATIO_W'(1)) ? '0 : cnt_q + RATIO_W'(1);
          sclk_d = (cnt_d >= lo_len);
        end
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= DIV_IDLE;
      ratio_q <= RATIO_W'(1);
      cnt_q   <= '0;
      sclk_q  <= 1'b0;
      rise_q  <= 1'b0;
      fall_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
      sclk_q  <= sclk_d;
      rise_q  <= ~sclk_q & sclk_d;
      fall_q  <= sclk_q & ~sclk_d;
      if (state_q == DIV_IDLE) ratio_q <= ratio_in;
    end
  end

  assign sclk     = sclk_q;
  assign rise_stb = rise_q;
  assign fall_stb = fall_q;

  // R5
  rise_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rise_q |-> (sclk_q && !$past(sclk_q)));
  // R5
  fall_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fall_q |-> (!sclk_q && $past(sclk_q)));
  // R5
  no_dual_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(rise_q && fall_q));
  // R6
  idle_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !go |=> (!sclk_q && !rise_q));
  // R8
  stop_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!go && sclk_q) |=> fall_q);
  // R7
  ratio_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q != DIV_IDLE) |=> $stable(ratio_q));

endmodule

// File: rtl/spi_clk_gen.sv
module spi_clk_gen
  import spi_clk_gen_pkg::*;
#(
  parameter int DIV_W = 4,
  parameter int EXT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [DIV_W-1:0] div_code,
  input  logic [EXT_W-1:0] ext_code,
  input  logic             fine_mode,
  input  logic             master_en,
  input  logic             run_en,
  output logic             sclk,
  output logic             rise_stb,
  output logic             fall_stb
);

  localparam int RATIO_W = ratio_width(DIV_W, EXT_W);

  logic [RATIO_W-1:0] ratio;
  logic               go;

  assign go = master_en & run_en;

  spi_div_ratio #(
    .DIV_W  (DIV_W),
    .EXT_W  (EXT_W),
    .RATIO_W(RATIO_W)
  ) u_ratio (
    .div_code (div_code),
    .ext_code (ext_code),
    .fine_mode(fine_mode),
    .ratio    (ratio)
  );

  spi_div_phase #(
    .RATIO_W(RATIO_W)
  ) u_phase (
    .clk     (clk),
    .rst_n   (rst_n),
    .go      (go),
    .ratio_in(ratio),
    .sclk    (sclk),
    .rise_stb(rise_stb),
    .fall_stb(fall_stb)
  );

  // R9
  reset_quiet_chk: assert property (@(posedge clk)
    !rst_n |-> (!sclk && !rise_stb && !fall_stb));

endmodule

// File: tb/spi_clk_gen_tb.sv
module spi_clk_gen_tb;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [3:0] div_code = '0;
  logic [7:0] ext_code = '0;
  logic       fine_mode = 1'b0;
  logic       master_en = 1'b1;
  logic       run_en = 1'b0;
  logic       sclk, rise_stb, fall_stb;

  int  n_checks = 0;
  int  n_errors = 0;
  bit  done = 0;

  always #10 clk = ~clk;

  spi_clk_gen u_dut (
    .clk(clk), .rst_n(rst_n), .div_code(div_code), .ext_code(ext_code),
    .fine_mode(fine_mode), .master_en(master_en), .run_en(run_en),
    .sclk(sclk), .rise_stb(rise_stb), .fall_stb(fall_stb)
  );

  // fine, ext, div, first rise, period, high width, requirement
  localparam int NV = 9;
  localparam int V_FINE [NV] = '{0, 0, 0, 0, 1, 1, 1, 1, 0};
  localparam int V_EXT  [NV] = '{0, 0, 0, 0, 0, 0, 1, 255, 171};
  localparam int V_DIV  [NV] = '{0, 1, 3, 15, 0, 4, 2, 15, 10};
  localparam int V_FIRST[NV] = '{1, 1, 4, 16384, 1, 3, 10, 2048, 512};
  localparam int V_PER  [NV] = '{2, 2, 8, 32768, 2, 5, 19, 4096, 1024};
  localparam int V_HIGH [NV] = '{1, 1, 4, 16384, 1, 2, 9, 2048, 512};
  localparam string V_REQ[NV] = '{"R4", "R1", "R1", "R1", "R4", "R2", "R2", "R2", "R1"};

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic measure(input int lim, output int r1, output int r2,
                         output int f1, output bit dual);
    r1 = -1; r2 = -1; f1 = -1; dual = 0;
    for (int t = 0; t < lim && r2 < 0; t++) begin
      @(negedge clk);
      if (rise_stb && fall_stb) dual = 1;
      if (rise_stb) begin
        if (r1 < 0) r1 = t;
        else r2 = t;
      end
      if (fall_stb && r1 >= 0 && f1 < 0) f1 = t;
    end
  endtask

  task automatic stop_gen();
    @(negedge clk);
    run_en = 1'b0;
    repeat (3) @(negedge clk);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      n_checks++;
      n_errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
      $finish;
    end
  end

  initial begin
    int r1, r2, f1, gap, bad;
    bit dual;
    // R9 reset state
    repeat (3) @(negedge clk);
    chk(!sclk && !rise_stb && !fall_stb, "R9 reset", {sclk, rise_stb, fall_stb}, 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    // Vector table: R1 R2 R3 R4 R5
    for (int i = 0; i < NV; i++) begin
      fine_mode = V_FINE[i][0];
      ext_code  = 8'(V_EXT[i]);
      div_code  = 4'(V_DIV[i]);
      @(negedge clk);
      run_en = 1'b1;
      measure(3 * V_PER[i] + 10, r1, r2, f1, dual);
      chk(r1 == V_FIRST[i], {V_REQ[i], " R3 first rise"}, r1, V_FIRST[i]);
      chk(r2 - r1 == V_PER[i], {V_REQ[i], " period"}, r2 - r1, V_PER[i]);
      chk(f1 - r1 == V_HIGH[i], "R3 high width", f1 - r1, V_HIGH[i]);
      chk(!dual, "R5 dual strobe", dual, 0);
      stop_gen();
    end

    // R6: no master, run requested
    master_en = 1'b0;
    fine_mode = 1'b0; div_code = 4'd1;
    @(negedge clk);
    run_en = 1'b1;
    bad = 0;
    for (int t = 0; t < 40; t++) begin
      @(negedge clk);
      if (sclk || rise_stb || fall_stb) bad++;
    end
    chk(bad == 0, "R6 gated by master_en", bad, 0);
    stop_gen();
    master_en = 1'b1;

    // R8: stop on the cycle sclk has just risen (ratio 8)
    div_code = 4'd3;
    @(negedge clk);
    run_en = 1'b1;
    gap = 0;
    while (!rise_stb && gap < 100) begin
      @(negedge clk);
      gap++;
    end
    run_en = 1'b0;
    @(negedge clk);
    chk(!sclk, "R8 sclk idle after stop", sclk, 0);
    chk(fall_stb, "R8 fall strobe on stop", fall_stb, 1);
    @(negedge clk);
    chk(!sclk && !rise_stb && !fall_stb, "R8 quiet after stop",
        {sclk, rise_stb, fall_stb}, 0);
    repeat (2) @(negedge clk);

    // R7: change config mid-run (start ratio 6)
    fine_mode = 1'b1; ext_code = 8'd0; div_code = 4'd5;
    @(negedge clk);
    run_en = 1'b1;
    gap = 0;
    while (!rise_stb && gap < 100) begin
      @(negedge clk);
      gap++;
    end
    div_code = 4'd0;
    gap = 0;
    do begin
      @(negedge clk);
      gap++;
    end while (!rise_stb && gap < 100);
    chk(gap == 6, "R7 ratio held while running", gap, 6);
    stop_gen();
    // R7: new setting applies at restart (ratio 1)
    run_en = 1'b1;
    measure(20, r1, r2, f1, dual);
    chk(r2 - r1 == 2, "R7 R4 new ratio after restart", r2 - r1, 2);
    stop_gen();

    done = 1;
    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end

endmodule